// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the device-side engine for a ring of transmit descriptors kept in local storage. The host fills descriptors and a local byte buffer through a simple write port, hands a descriptor to the device by setting its ownership bit, and then pulses a demand strobe. The engine walks the ring from its current position. For every device-owned entry it streams the frame bytes out over a ready/valid byte interface, optionally extending short frames with zero bytes. It then waits for a per-frame outcome from the downstream transmitter, writes completion status into the descriptor, hands the entry back to the host and pulses an interrupt.

The scan stops at the first host-owned entry and keeps its position, so the next demand resumes exactly there. Entries that cannot be sent as a single-buffer frame are returned at once with a buffer error. No bytes are emitted for them.

Top module: `txring_reader`

## Requirements
- R1: The ring has 2^ringLog2 entries (ringLog2 is clamped to the index width parameter). The ring index is 0 after reset, steps by one per completed entry and wraps from the last entry to 0.
- R2: A demand pulse starts a scan at the current index. An entry is processed only when bit 31 of its status word (word 1) is 1. The scan stops at the first entry with that bit clear, emits no bytes for it and leaves the index on it.
- R3: The frame length is the two's-complement negation of word 1 bits [15:0]. Bytes are read from the buffer RAM starting at the address held in the low bits of word 0, in increasing (wrapping) address order. txLast marks the final byte.
- R4: A byte moves when txValid and txReady are both 1. While txValid is 1 and txReady is 0, txValid, txData and txLast hold their values.
- R5: With autoPad at 1, a frame shorter than 60 bytes is sent as 60 bytes, the extra bytes being zero. With autoPad at 0, exactly the described length is sent.
- R6: After the last byte the engine waits for resValid. The bits of resFlags are: 0 deferred, 1 one retry, 2 several retries, 3 retries exhausted, 4 carrier lost, 5 late collision, 6 underflow. Write-back clears word 1 bit 31 and copies flags 0, 1 and 2 into word 1 bits 26, 27 and 28. Word 1 bit 30 is set to the OR of all word 2 error bits. The other bits of word 1 are kept.
- R7: Word 2 is rewritten at completion: bit 31 buffer error, bit 30 underflow, bit 28 late collision, bit 27 carrier lost, bit 26 retries exhausted, and every other bit 0.
- R8: txInt is a one-cycle pulse per completed entry. It is high in the cycle after the write-back, when the updated descriptor can already be read. It is never high while txValid is high.
- R9: An owned entry lacking word 1 bit 25 (start) or bit 24 (end), or with length 0 while autoPad is 0, sends no bytes. It is returned with word 2 bit 31 and word 1 bit 30 set and bit 31 cleared, raises txInt, and the scan continues with the next entry.
- R10: hostAddr is {entry, word[1:0]}. Words 0 to 2 are writable and readable, and word 3 always reads 0. Reads are combinational, and every descriptor word is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringLog2 | input | 4 | Log2 of ring size |
| autoPad | input | 1 | Pad short frames to 60 bytes |
| txDemand | input | 1 | Poll request pulse |
| hostWe | input | 1 | Descriptor word write enable |
| hostAddr | input | IDX_W+2 | Descriptor word address {entry, word} |
| hostWdata | input | 32 | Descriptor write data |
| hostRdata | output | 32 | Descriptor read data |
| bufWe | input | 1 | Buffer RAM write enable |
| bufAddr | input | BUF_AW | Buffer RAM byte address |
| bufWdata | input | 8 | Buffer RAM write data |
| txValid | output | 1 | Output byte valid |
| txReady | input | 1 | Downstream accepts byte |
| txData | output | 8 | Output byte |
| txLast | output | 1 | Final byte of frame |
| resValid | input | 1 | Frame outcome strobe |
| resFlags | input | 7 | Frame outcome flags |
| txInt | output | 1 | Completion pulse |

## Verification
A wrong ring index shows up as bytes from the wrong buffer region on the very next frame, or as a completion landing in an entry other than the one read back. Either is visible within one frame of the fault. A corrupted length or fill count changes the number of handshakes before txLast, or lets non-zero bytes into the pad region, and the bench sees this on that same frame. A bad write-back merge is caught by reading both status words back in the cycle txInt rises. A scan that fails to stop shows up as stream activity or extra interrupts during an idle window after the ring is exhausted.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int OWN_BIT  = 31;
  localparam int ERR_BIT  = 30;
  localparam int MORE_BIT = 28;
  localparam int ONE_BIT  = 27;
  localparam int DEF_BIT  = 26;
  localparam int STP_BIT  = 25;
  localparam int ENP_BIT  = 24;

  localparam int BUFF_BIT = 31;
  localparam int UFLO_BIT = 30;
  localparam int LCOL_BIT = 28;
  localparam int LCAR_BIT = 27;
  localparam int RTRY_BIT = 26;

  localparam int RES_DEF  = 0;
  localparam int RES_ONE  = 1;
  localparam int RES_MORE = 2;
  localparam int RES_RTRY = 3;
  localparam int RES_LCAR = 4;
  localparam int RES_LCOL = 5;
  localparam int RES_UFLO = 6;
  localparam int RES_W    = 7;

  localparam logic [15:0] MIN_FRAME = 16'd60;

  typedef struct packed {
    logic loadFrame;
    logic advanceByte;
    logic writeBack;
    logic bufErr;
  } dpStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SEND,
    ST_WAITRES
  } scanState_t;
endpackage

// File: rtl/txring_datapath.sv
module txring_datapath
  import txring_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int BUF_AW = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  input  logic [IDX_W-1:0]   ringIdx,
  input  logic               autoPad,
  input  logic               hostWe,
  input  logic [IDX_W+1:0]   hostAddr,
  input  logic [31:0]        hostWdata,
  output logic [31:0]        hostRdata,
  input  logic               bufWe,
  input  logic [BUF_AW-1:0]  bufAddr,
  input  logic [7:0]         bufWdata,
  input  logic [RES_W-1:0]   resFlags,
  output logic [7:0]         txData,
  output logic               lastByte,
  output logic               curOwn,
  output logic               curBad
);
  localparam int ENTRIES    = 1 << IDX_W;
  localparam int DESC_WORDS = ENTRIES * 4;
  localparam int BUF_BYTES  = 1 << BUF_AW;

  logic [31:0] descMem [DESC_WORDS];
  logic [7:0]  bufMem  [BUF_BYTES];

  logic [IDX_W+1:0]  word0Addr, word1Addr, word2Addr;
  logic [31:0]       curWord0, curWord1, wbWord1, wbWord2;
  logic [RES_W-1:0]  effFlags;
  logic [15:0]       rawLen, padLen;
  logic [15:0]       frameLen, dataLen, byteCnt;
  logic [BUF_AW-1:0] baseAddr, rdAddr;

  assign word0Addr = {ringIdx, 2'd0};
  assign word1Addr = {ringIdx, 2'd1};
  assign word2Addr = {ringIdx, 2'd2};
  assign curWord0  = descMem[word0Addr];
  assign curWord1  = descMem[word1Addr];

  assign rawLen = 16'd0 - curWord1[15:0];
  assign padLen = (autoPad && (rawLen < MIN_FRAME)) ? MIN_FRAME : rawLen;
  assign curOwn = curWord1[OWN_BIT];
  assign curBad = !(curWord1[STP_BIT] && curWord1[ENP_BIT]) ||
                  ((rawLen == 16'd0) && !autoPad);

  assign hostRdata = (hostAddr[1:0] == 2'd3) ? 32'd0 : descMem[hostAddr];

  // completion words merged from the outcome flags
  assign effFlags = strobes.bufErr ? '0 : resFlags;

  always_comb begin
    wbWord2           = '0;
    wbWord2[BUFF_BIT] = strobes.bufErr;
    wbWord2[UFLO_BIT] = effFlags[RES_UFLO];
    wbWord2[LCOL_BIT] = effFlags[RES_LCOL];
    wbWord2[LCAR_BIT] = effFlags[RES_LCAR];
    wbWord2[RTRY_BIT] = effFlags[RES_RTRY];

    wbWord1           = curWord1;
    wbWord1[OWN_BIT]  = 1'b0;
    wbWord1[ERR_BIT]  = |wbWord2;
    wbWord1[MORE_BIT] = effFlags[RES_MORE];
    wbWord1[ONE_BIT]  = effFlags[RES_ONE];
    wbWord1[DEF_BIT]  = effFlags[RES_DEF];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DESC_WORDS; i++) descMem[i] <= '0;
    end else if (strobes.writeBack) begin
      descMem[word1Addr] <= wbWord1;
      descMem[word2Addr] <= wbWord2;
    end else if (hostWe && (hostAddr[1:0] != 2'd3)) begin
      descMem[hostAddr] <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (bufWe) bufMem[bufAddr] <= bufWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameLen <= '0;
      dataLen  <= '0;
      byteCnt  <= '0;
      baseAddr <= '0;
    end else if (strobes.loadFrame) begin
      frameLen <= padLen;
      dataLen  <= rawLen;
      byteCnt  <= '0;
      baseAddr <= curWord0[BUF_AW-1:0];
    end else if (strobes.advanceByte) begin
      byteCnt <= byteCnt + 16'd1;
    end
  end

  assign rdAddr   = baseAddr + byteCnt[BUF_AW-1:0];
  assign txData   = (byteCnt < dataLen) ? bufMem[rdAddr] : 8'h00;
  assign lastByte = (byteCnt == (frameLen - 16'd1));
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       ringLog2,
  input  logic             txDemand,
  input  logic             txReady,
  input  logic             resValid,
  input  logic             curOwn,
  input  logic             curBad,
  input  logic             lastByte,
  output dpStrobes_t       strobes,
  output logic [IDX_W-1:0] ringIdx,
  output logic             txValid,
  output logic             txLast,
  output logic             txInt
);
  scanState_t       state, nextState;
  logic             demandPend;
  logic             idxStep;
  logic [3:0]       effLog;
  logic [IDX_W:0]   ringSize;
  logic [IDX_W-1:0] idxMask;

  assign effLog   = (ringLog2 > 4'(IDX_W)) ? 4'(IDX_W) : ringLog2;
  assign ringSize = (IDX_W+1)'(1) << effLog;
  assign idxMask  = IDX_W'(ringSize - 1'b1);

  always_comb begin
    strobes   = '0;
    nextState = state;
    idxStep   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (txDemand || demandPend) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (!curOwn) begin
          nextState = ST_IDLE;
        end else if (curBad) begin
          strobes.writeBack = 1'b1;
          strobes.bufErr    = 1'b1;
          idxStep           = 1'b1;
        end else begin
          strobes.loadFrame = 1'b1;
          nextState         = ST_SEND;
        end
      end
      ST_SEND: begin
        if (txReady) begin
          strobes.advanceByte = 1'b1;
          if (lastByte) nextState = ST_WAITRES;
        end
      end
      ST_WAITRES: begin
        if (resValid) begin
          strobes.writeBack = 1'b1;
          idxStep           = 1'b1;
          nextState         = ST_CHECK;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ringIdx    <= '0;
      demandPend <= 1'b0;
      txInt      <= 1'b0;
    end else begin
      state <= nextState;
      txInt <= strobes.writeBack;
      if (idxStep) ringIdx <= (ringIdx + 1'b1) & idxMask;
      if (state == ST_IDLE)  demandPend <= 1'b0;
      else if (txDemand)     demandPend <= 1'b1;
    end
  end

  assign txValid = (state == ST_SEND);
  assign txLast  = txValid && lastByte;
endmodule

// File: rtl/txring_reader.sv
module txring_reader
  import txring_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int BUF_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        ringLog2,
  input  logic              autoPad,
  input  logic              txDemand,
  input  logic              hostWe,
  input  logic [IDX_W+1:0]  hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  input  logic              bufWe,
  input  logic [BUF_AW-1:0] bufAddr,
  input  logic [7:0]        bufWdata,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txLast,
  input  logic              resValid,
  input  logic [6:0]        resFlags,
  output logic              txInt
);
  dpStrobes_t       strobes;
  logic [IDX_W-1:0] ringIdx;
  logic             curOwn, curBad, lastByte;

  txring_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ringLog2(ringLog2), .txDemand(txDemand),
    .txReady(txReady), .resValid(resValid), .curOwn(curOwn), .curBad(curBad),
    .lastByte(lastByte), .strobes(strobes), .ringIdx(ringIdx),
    .txValid(txValid), .txLast(txLast), .txInt(txInt)
  );

  txring_datapath #(.IDX_W(IDX_W), .BUF_AW(BUF_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ringIdx(ringIdx),
    .autoPad(autoPad), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .bufWe(bufWe),
    .bufAddr(bufAddr), .bufWdata(bufWdata), .resFlags(resFlags),
    .txData(txData), .lastByte(lastByte), .curOwn(curOwn), .curBad(curBad)
  );
endmodule

// File: rtl/txring_checker.sv
module txring_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             txValid,
  input logic             txReady,
  input logic [7:0]       txData,
  input logic             txLast,
  input logic             txInt,
  input logic [IDX_W-1:0] ringIdx,
  input logic [15:0]      byteCnt,
  input logic [15:0]      dataLen
);
  a_r8_no_int_in_send: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !txInt);

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));

  a_r3_last_ends_frame: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLast) |=> !txValid);

  a_r1_idx_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ringIdx) |-> ((ringIdx == '0) || (ringIdx == IDX_W'($past(ringIdx) + 1'b1))));

  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && (byteCnt >= dataLen)) |-> (txData == 8'h00));
endmodule

bind txring_reader txring_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .txData(txData), .txLast(txLast), .txInt(txInt),
  .ringIdx(u_ctrl.ringIdx), .byteCnt(u_dp.byteCnt), .dataLen(u_dp.dataLen)
);

// File: tb/sim_txring_reader.sv
`timescale 1ns/1ps
module sim_txring_reader;
  localparam int IDX_W  = 4;
  localparam int BUF_AW = 10;
  localparam int BUF_N  = 1 << BUF_AW;

  logic              clk = 1'b0;
  logic              rstN;
  logic [3:0]        ringLog2;
  logic              autoPad;
  logic              txDemand;
  logic              hostWe;
  logic [IDX_W+1:0]  hostAddr;
  logic [31:0]       hostWdata;
  logic [31:0]       hostRdata;
  logic              bufWe;
  logic [BUF_AW-1:0] bufAddr;
  logic [7:0]        bufWdata;
  logic              txValid, txReady, txLast, resValid, txInt;
  logic [7:0]        txData;
  logic [6:0]        resFlags;

  logic [7:0] bufShadow [BUF_N];
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int expIdx = 0;
  int ringMask = 3;

  txring_reader #(.IDX_W(IDX_W), .BUF_AW(BUF_AW)) u0 (
    .clk(clk), .rstN(rstN), .ringLog2(ringLog2), .autoPad(autoPad),
    .txDemand(txDemand), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .bufWe(bufWe),
    .bufAddr(bufAddr), .bufWdata(bufWdata), .txValid(txValid),
    .txReady(txReady), .txData(txData), .txLast(txLast),
    .resValid(resValid), .resFlags(resFlags), .txInt(txInt)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkW1(input bit own, input bit stp, input bit enp, input int len);
    logic [15:0] neg;
    neg = 16'(0 - len);
    return {own, 5'b0, stp, enp, 8'h00, neg};
  endfunction

  function automatic logic [31:0] expWord1(input logic [31:0] w1, input logic [6:0] f, input bit bad);
    logic [31:0] r;
    r = w1;
    r[31] = 1'b0;
    if (bad) begin
      r[30] = 1'b1;
    end else begin
      r[26] = f[0]; r[27] = f[1]; r[28] = f[2];
      r[30] = |f[6:3];
    end
    return r;
  endfunction

  function automatic logic [31:0] expWord2(input logic [6:0] f, input bit bad);
    logic [31:0] r;
    r = '0;
    if (bad) r[31] = 1'b1;
    else begin
      r[30] = f[6]; r[28] = f[5]; r[27] = f[4]; r[26] = f[3];
    end
    return r;
  endfunction

  task automatic hostWrite(input int addr, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = (IDX_W+2)'(addr); hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input int addr, output logic [31:0] d);
    hostAddr = (IDX_W+2)'(addr);
    #1;
    d = hostRdata;
  endtask

  task automatic descWrite(input int idx, input int base, input logic [31:0] w1);
    hostWrite(idx * 4 + 0, 32'(base));
    hostWrite(idx * 4 + 1, w1);
    hostWrite(idx * 4 + 2, 32'd0);
  endtask

  task automatic fillBuf(input int base, input int len);
    for (int i = 0; i < len; i++) begin
      int a;
      logic [7:0] v;
      a = (base + i) % BUF_N;
      v = 8'($urandom);
      @(negedge clk);
      bufWe = 1'b1; bufAddr = BUF_AW'(a); bufWdata = v;
      bufShadow[a] = v;
    end
    @(negedge clk);
    bufWe = 1'b0;
  endtask

  task automatic demand();
    @(negedge clk);
    txDemand = 1'b1;
    @(negedge clk);
    txDemand = 1'b0;
  endtask

  task automatic readBack(input int idx, input logic [31:0] w1, input logic [6:0] f, input bit bad, input string req);
    logic [31:0] d;
    hostRead(idx * 4 + 1, d);
    check(d === expWord1(w1, f, bad), {req, " word1 writeback"}, d, expWord1(w1, f, bad));
    hostRead(idx * 4 + 2, d);
    check(d === expWord2(f, bad), {req, " word2 writeback"}, d, expWord2(f, bad));
  endtask

  // R3 R4 R5 R6 R7 R8: stream one frame, return a random outcome, verify completion
  task automatic runFrame(input int idx, input logic [31:0] w1, input int base, input int len, input bit padOn, input string req);
    int expLen, got, guard;
    bit ok, done;
    logic [7:0] exp, badAct, badExp;
    logic [6:0] f;
    expLen = (padOn && len < 60) ? 60 : len;
    got = 0; guard = 0; ok = 1'b1; done = 1'b0; badAct = 0; badExp = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      txReady = ($urandom % 4) != 0;
      #1;
      if (txValid && txReady) begin
        exp = (got < len) ? bufShadow[(base + got) % BUF_N] : 8'h00;
        if (txData !== exp && ok) begin ok = 1'b0; badAct = txData; badExp = exp; end
        if (txLast) done = 1'b1;
        got++;
      end
    end
    check(ok, {req, " byte content"}, 32'(badAct), 32'(badExp));
    check(got == expLen, {req, " frame length"}, 32'(got), 32'(expLen));
    f = 7'($urandom);
    @(negedge clk);
    txReady = 1'b0; resValid = 1'b1; resFlags = f;
    @(negedge clk);
    resValid = 1'b0;
    #1;
    check(txInt === 1'b1, "R8 txInt after completion", 32'(txInt), 32'd1);
    readBack(idx, w1, f, 1'b0, "R6 R7");
  endtask

  // R9: owned but unsendable entry
  task automatic runBad(input int idx, input logic [31:0] w1);
    bit sawValid, sawInt;
    sawValid = 1'b0; sawInt = 1'b0;
    for (int i = 0; i < 20 && !sawInt; i++) begin
      @(negedge clk);
      #1;
      if (txValid) sawValid = 1'b1;
      if (txInt) sawInt = 1'b1;
    end
    check(!sawValid && sawInt, "R9 bad entry skipped with txInt", {30'd0, sawValid, sawInt}, 32'd1);
    readBack(idx, w1, 7'd0, 1'b1, "R9");
  endtask

  task automatic idleWindow(input string req);
    bit busy;
    busy = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      if (txValid || txInt) busy = 1'b1;
    end
    check(!busy, req, 32'(busy), 32'd0);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] w1a, w1b, w1c;
    void'($urandom(32'd1234));
    rstN = 1'b0; ringLog2 = 4'd2; autoPad = 1'b1; txDemand = 1'b0;
    hostWe = 1'b0; hostAddr = '0; hostWdata = '0; bufWe = 1'b0; bufAddr = '0;
    bufWdata = '0; txReady = 1'b0; resValid = 1'b0; resFlags = '0;
    for (int i = 0; i < BUF_N; i++) bufShadow[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(txValid === 1'b0 && txInt === 1'b0, "R8 reset outputs idle", {30'd0, txValid, txInt}, 32'd0);
    hostRead(1, d);
    check(d === 32'd0, "R10 descriptor cleared by reset", d, 32'd0);

    // Directed: 4-entry ring, pads of 10, 60, 61 bytes (R5), halt at entry 3 (R2)
    fillBuf(0, 10); fillBuf(256, 60); fillBuf(512, 61);
    w1a = mkW1(1, 1, 1, 10); w1b = mkW1(1, 1, 1, 60); w1c = mkW1(1, 1, 1, 61);
    descWrite(0, 0, w1a); descWrite(1, 256, w1b); descWrite(2, 512, w1c);
    descWrite(3, 768, mkW1(0, 1, 1, 8));
    hostRead(0, d);
    check(d === 32'd0, "R10 word0 readback", d, 32'd0);
    hostRead(3, d);
    check(d === 32'd0, "R10 word3 reads zero", d, 32'd0);
    demand();
    runFrame(0, w1a, 0, 10, 1, "R5 pad 10 to 60");
    runFrame(1, w1b, 256, 60, 1, "R5 exact 60");
    runFrame(2, w1c, 512, 61, 1, "R3 61 bytes");
    idleWindow("R2 scan halts at host-owned entry");

    // Wrap 3 -> 0 (R1) with autoPad off (R5 exact short lengths)
    autoPad = 1'b0;
    fillBuf(768, 5); fillBuf(1000, 40);
    w1a = mkW1(1, 1, 1, 5); w1b = mkW1(1, 1, 1, 40);
    descWrite(3, 768, w1a); descWrite(0, 1000, w1b);
    demand();
    runFrame(3, w1a, 768, 5, 0, "R5 no pad 5 bytes");
    runFrame(0, w1b, 1000, 40, 0, "R1 wrap to entry 0, buffer address wrap");
    idleWindow("R2 halt after wrap");

    // Bad entries at 1 (no start bit) and 2 (zero length, no pad), halt at 3 (R9)
    w1a = mkW1(1, 0, 1, 20); w1b = mkW1(1, 1, 1, 0);
    descWrite(1, 0, w1a); descWrite(2, 0, w1b);
    demand();
    runBad(1, w1a);
    runBad(2, w1b);
    idleWindow("R2 halt after bad entries");
    expIdx = 3;

    // Random phase on an 8-entry ring
    ringLog2 = 4'd3; ringMask = 7;
    for (int r = 0; r < 25; r++) begin
      int k;
      int bases [3];
      int lens [3];
      bit bads [3];
      logic [31:0] w1s [3];
      k = 1 + ($urandom % 3);
      autoPad = $urandom % 2;
      for (int j = 0; j < k; j++) begin
        bases[j] = j * 256 + ($urandom % 100);
        lens[j]  = 1 + ($urandom % 100);
        bads[j]  = ($urandom % 8) == 0;
        fillBuf(bases[j], lens[j]);
        w1s[j] = mkW1(1, !bads[j], 1, lens[j]);
        descWrite((expIdx + j) & ringMask, bases[j], w1s[j]);
      end
      descWrite((expIdx + k) & ringMask, 0, 32'd0);
      demand();
      for (int j = 0; j < k; j++) begin
        if (bads[j]) runBad((expIdx + j) & ringMask, w1s[j]);
        else runFrame((expIdx + j) & ringMask, w1s[j], bases[j], lens[j], autoPad, "R3 R1 random frame");
      end
      expIdx = (expIdx + k) & ringMask;
    end
    idleWindow("R2 idle after random phase");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule